// File: doc/BRIEF.md
# Buffered Asynchronous Serial Channel

This block is one full-duplex asynchronous serial channel that a processor reaches through a small register bus. The channel has an active-low select. Bytes written to the data register go into a transmit queue. A shifter frames each byte with a start bit, eight data bits sent least significant bit first, an optional parity bit and one stop bit, and sends it on `txd`. The receiver locks onto each start bit on `rxd`. It samples every bit at its midpoint on a 16x oversampling grid, checks parity and the stop bit, and stores the byte in a receive queue.

After reset both queues hold only one byte, so the channel acts as a plain single-holding-register device. When software sets the queue enable bit, each queue grows to `DEPTH` entries. The interrupt then fires once the receive occupancy reaches one of four programmable levels. The bit rate is the clock divided by 16 times a 16-bit divisor.

Register map (`addr`): 0 data (a write pushes a transmit byte, a read pops a receive byte); 1 line control (bit 0 parity enable, bit 1 odd parity); 2 queue control (write: bit 0 enable, bit 1 receive flush, bit 2 transmit flush, bits 7:6 level; read: level in bits 7:6 and enable in bit 0); 3 divisor low byte; 4 divisor high byte; 5 status.

Top module: `uart_chan`

## Requirements
- R1: After reset the status register reads 0x60, queue control reads 0x00, `irq` is 0 and `txd` is 1.
- R2: With queues disabled the receive side holds one byte. A byte arriving while it is occupied is dropped and sets the overrun bit (status bit 1). The stored byte stays readable.
- R3: A transmitted frame is a low start bit, then data LSB first, then a high stop bit.
- R4: With line control bit 0 set, a parity bit follows the data. It makes the count of ones even when bit 1 is 0, and odd when bit 1 is 1.
- R5: A received parity bit that does not match the configured parity sets status bit 2.
- R6: A low line at the stop-bit midpoint sets status bit 3.
- R7: With queues enabled each queue holds DEPTH (16) bytes in arrival order. A 17th received byte is dropped and sets overrun.
- R8: With queues enabled, `irq` is high exactly when receive occupancy is at least the level selected by control bits 7:6: 00=1, 01=4, 10=8, 11=14. With queues disabled, `irq` follows data-ready.
- R9: Reading the status register clears bits 1 to 3. Bit 0 is data-ready, bit 5 is transmit queue empty and bit 6 is transmitter idle.
- R10: A bus write while `cs_n` is high changes no register.
- R11: Every bit lasts 16 times the divisor in clock cycles.
- R12: A queue control write with bit 1 set empties the receive queue at once. Changing the enable bit empties both queues.
- R13: Status bit 6 is 0 from the write of a byte until its stop bit has been sent, and 1 afterwards.
- R14: A low pulse on `rxd` shorter than half a bit does not start a character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock and oversampling base |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select for bus access |
| wr_en | input | 1 | Write strobe, sampled at the clock edge |
| rd_en | input | 1 | Read strobe; pops or clears on the edge |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| rxd | input | 1 | Serial input |
| txd | output | 1 | Serial output, high when idle |
| irq | output | 1 | Receive interrupt |

## Verification
On every cycle the checker enforces several relations. Receive occupancy stays within one byte in holding-register mode and within DEPTH with queues enabled. `irq` is never high over an empty receive queue. A flush empties the queue on the next cycle, and a byte arriving at a full queue always leaves the overrun flag set. The divisor holds steady whenever the channel is not selected. Frame layout, parity polarity, bit duration, glitch rejection, trigger thresholds, byte order through the queues and clear-on-read show up only in the bench scenarios. There the bench drives and samples the serial lines at mid-bit and compares against its own queue of expected bytes.

// File: rtl/uart_pkg.sv
package uart_pkg;
   localparam int DIV_W = 16;
   localparam logic [2:0] A_DATA = 3'd0;
   localparam logic [2:0] A_LINE = 3'd1;
   localparam logic [2:0] A_QCTL = 3'd2;
   localparam logic [2:0] A_DIVL = 3'd3;
   localparam logic [2:0] A_DIVH = 3'd4;
   localparam logic [2:0] A_STAT = 3'd5;

   typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP} rx_state_t;

   function automatic logic par_bit(input logic [7:0] d, input logic odd);
      return (^d) ^ odd;
   endfunction
endpackage

// File: rtl/uart_fifo.sv
module uart_fifo #(
   parameter int W = 8,
   parameter int DEPTH = 16,
   localparam int AW = $clog2(DEPTH),
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic [CW-1:0] limit,
   input  logic          push,
   input  logic [W-1:0]  din,
   input  logic          pop,
   output logic [W-1:0]  dout,
   output logic [CW-1:0] count
);
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("uart_fifo: DEPTH must be a power of two, at least 2");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic          do_push, do_pop;

   assign do_push = push && (count < limit);
   assign do_pop  = pop && (count != '0);
   assign dout    = mem[rp];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp <= '0;
         rp <= '0;
         count <= '0;
      end else if (flush) begin
         wp <= '0;
         rp <= '0;
         count <= '0;
      end else begin
         if (do_push) wp <= wp + 1'b1;
         if (do_pop)  rp <= rp + 1'b1;
         count <= count + CW'(do_push) - CW'(do_pop);
      end
   end

   always_ff @(posedge clk) begin
      if (do_push && !flush) mem[wp] <= din;
   end
endmodule

// File: rtl/uart_baud.sv
module uart_baud #(
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [DW-1:0] div,
   output logic          tick
);
   logic [DW-1:0] cnt, lim;

   assign lim  = (div == '0) ? '0 : div - 1'b1;
   assign tick = (cnt >= lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (tick) cnt <= '0;
      else           cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/uart_tx.sv
module uart_tx
   import uart_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       par_en,
   input  logic       par_odd,
   input  logic       have,
   input  logic [7:0] din,
   output logic       take,
   output logic       txd,
   output logic       busy
);
   localparam int FW = 11;
   logic [FW-1:0] sh;
   logic [3:0]    sub, bitn, last;

   assign take = !busy && have && tick;
   assign last = par_en ? 4'd10 : 4'd9;
   assign txd  = sh[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh <= '1;
         sub <= '0;
         bitn <= '0;
         busy <= 1'b0;
      end else if (take) begin
         busy <= 1'b1;
         sub <= '0;
         bitn <= '0;
         sh <= par_en ? {1'b1, par_bit(din, par_odd), din, 1'b0}
                      : {2'b11, din, 1'b0};
      end else if (busy && tick) begin
         if (sub == 4'd15) begin
            sub <= '0;
            sh <= {1'b1, sh[FW-1:1]};
            bitn <= bitn + 1'b1;
            if (bitn == last) busy <= 1'b0;
         end else begin
            sub <= sub + 1'b1;
         end
      end
   end
endmodule

// File: rtl/uart_rx.sv
module uart_rx
   import uart_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       par_en,
   input  logic       par_odd,
   input  logic       rxd,
   output logic       valid,
   output logic [7:0] data,
   output logic       perr,
   output logic       ferr
);
   logic [1:0] sync;
   logic       line, pbit;
   logic [3:0] sub;
   logic [2:0] bitn;
   rx_state_t  st;

   assign line = sync[1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync <= 2'b11;
         st <= RX_IDLE;
         sub <= '0;
         bitn <= '0;
         pbit <= 1'b0;
         data <= '0;
         valid <= 1'b0;
         perr <= 1'b0;
         ferr <= 1'b0;
      end else begin
         sync <= {sync[0], rxd};
         valid <= 1'b0;
         if (tick) begin
            unique case (st)
               RX_IDLE: if (!line) begin
                  st <= RX_START;
                  sub <= '0;
               end
               RX_START: if (sub == 4'd7) begin
                  sub <= '0;
                  bitn <= '0;
                  st <= line ? RX_IDLE : RX_DATA;
               end else sub <= sub + 1'b1;
               RX_DATA: if (sub == 4'd15) begin
                  sub <= '0;
                  data <= {line, data[7:1]};
                  bitn <= bitn + 1'b1;
                  if (bitn == 3'd7) st <= par_en ? RX_PAR : RX_STOP;
               end else sub <= sub + 1'b1;
               RX_PAR: if (sub == 4'd15) begin
                  sub <= '0;
                  pbit <= line;
                  st <= RX_STOP;
               end else sub <= sub + 1'b1;
               RX_STOP: if (sub == 4'd15) begin
                  sub <= '0;
                  valid <= 1'b1;
                  ferr <= !line;
                  perr <= par_en && (pbit != par_bit(data, par_odd));
                  st <= RX_IDLE;
               end else sub <= sub + 1'b1;
               default: st <= RX_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/uart_chan.sv
module uart_chan
   import uart_pkg::*;
#(
   parameter int DEPTH = 16,
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cs_n,
   input  logic       wr_en,
   input  logic       rd_en,
   input  logic [2:0] addr,
   input  logic [7:0] wdata,
   output logic [7:0] rdata,
   input  logic       rxd,
   output logic       txd,
   output logic       irq
);
   if (DEPTH < 16) begin : g_bad_depth
      $error("uart_chan: DEPTH below 16 cannot hold the highest level");
   end

   localparam logic [CW-1:0] LVL0 = CW'(1);
   localparam logic [CW-1:0] LVL1 = CW'(DEPTH / 4);
   localparam logic [CW-1:0] LVL2 = CW'(DEPTH / 2);
   localparam logic [CW-1:0] LVL3 = CW'(DEPTH - 2);

   logic [1:0]       lcr, lvl;
   logic             fifo_en;
   logic [DIV_W-1:0] div;
   logic             wr_hit, rd_hit, q_wr, rx_flush, tx_flush, stat_rd;
   logic             tick, take, tx_busy;
   logic             rx_valid, rx_perr, rx_ferr, rx_full;
   logic             ovr_err, par_err, frm_err;
   logic [7:0]       rx_byte, rx_dout, tx_dout, stat;
   logic [CW-1:0]    limit, rx_cnt, tx_cnt, trig;

   assign wr_hit   = !cs_n && wr_en;
   assign rd_hit   = !cs_n && rd_en;
   assign q_wr     = wr_hit && (addr == A_QCTL);
   assign rx_flush = q_wr && (wdata[1] || (wdata[0] != fifo_en));
   assign tx_flush = q_wr && (wdata[2] || (wdata[0] != fifo_en));
   assign stat_rd  = rd_hit && (addr == A_STAT);
   assign limit    = fifo_en ? CW'(DEPTH) : CW'(1);
   assign rx_full  = (rx_cnt >= limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lcr <= '0;
         lvl <= '0;
         fifo_en <= 1'b0;
         div <= DIV_W'(1);
         ovr_err <= 1'b0;
         par_err <= 1'b0;
         frm_err <= 1'b0;
      end else begin
         if (wr_hit) begin
            case (addr)
               A_LINE: lcr <= wdata[1:0];
               A_QCTL: begin
                  fifo_en <= wdata[0];
                  lvl <= wdata[7:6];
               end
               A_DIVL: div[7:0] <= wdata;
               A_DIVH: div[DIV_W-1:8] <= wdata[DIV_W-9:0];
               default: ;
            endcase
         end
         ovr_err <= (ovr_err && !stat_rd) || (rx_valid && rx_full);
         par_err <= (par_err && !stat_rd) || (rx_valid && !rx_full && rx_perr);
         frm_err <= (frm_err && !stat_rd) || (rx_valid && !rx_full && rx_ferr);
      end
   end

   uart_baud #(.DW(DIV_W)) u_baud (.clk(clk), .rst_n(rst_n), .div(div), .tick(tick));

   uart_fifo #(.W(8), .DEPTH(DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n), .flush(tx_flush), .limit(limit),
      .push(wr_hit && (addr == A_DATA)), .din(wdata),
      .pop(take), .dout(tx_dout), .count(tx_cnt));

   uart_fifo #(.W(8), .DEPTH(DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n), .flush(rx_flush), .limit(limit),
      .push(rx_valid), .din(rx_byte),
      .pop(rd_hit && (addr == A_DATA)), .dout(rx_dout), .count(rx_cnt));

   uart_tx u_tx (
      .clk(clk), .rst_n(rst_n), .tick(tick), .par_en(lcr[0]), .par_odd(lcr[1]),
      .have(tx_cnt != '0), .din(tx_dout), .take(take), .txd(txd), .busy(tx_busy));

   uart_rx u_rx (
      .clk(clk), .rst_n(rst_n), .tick(tick), .par_en(lcr[0]), .par_odd(lcr[1]),
      .rxd(rxd), .valid(rx_valid), .data(rx_byte), .perr(rx_perr), .ferr(rx_ferr));

   always_comb begin
      unique case (lvl)
         2'b00: trig = LVL0;
         2'b01: trig = LVL1;
         2'b10: trig = LVL2;
         default: trig = LVL3;
      endcase
   end

   assign irq  = fifo_en ? (rx_cnt >= trig) : (rx_cnt != '0);
   assign stat = {1'b0, (tx_cnt == '0) && !tx_busy, tx_cnt == '0, 1'b0,
                  frm_err, par_err, ovr_err, rx_cnt != '0};

   always_comb begin
      case (addr)
         A_DATA:  rdata = rx_dout;
         A_LINE:  rdata = {6'b0, lcr};
         A_QCTL:  rdata = {lvl, 5'b0, fifo_en};
         A_DIVL:  rdata = div[7:0];
         A_DIVH:  rdata = 8'(div >> 8);
         A_STAT:  rdata = stat;
         default: rdata = 8'h00;
      endcase
   end
endmodule

// File: rtl/uart_chan_chk.sv
module uart_chan_chk
   import uart_pkg::*;
#(
   parameter int DEPTH = 16,
   localparam int CW = $clog2(DEPTH + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cs_n,
   input logic             wr_en,
   input logic [2:0]       addr,
   input logic             flush_bit,
   input logic             irq,
   input logic             fifo_en,
   input logic [CW-1:0]    rx_cnt,
   input logic [DIV_W-1:0] div,
   input logic             rx_valid,
   input logic             rx_full,
   input logic             ovr_err
);
   a_r2_single_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !fifo_en |-> rx_cnt <= CW'(1));

   a_r7_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
      rx_cnt <= CW'(DEPTH));

   a_r8_irq_has_data: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> rx_cnt != '0);

   a_r10_unselected_hold: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |=> $stable(div));

   a_r12_rx_flush: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && wr_en && addr == A_QCTL && flush_bit) |=> rx_cnt == '0);

   a_r2_overrun_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && rx_full) |=> ovr_err);
endmodule

bind uart_chan uart_chan_chk #(.DEPTH(DEPTH)) u_chk (
   .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_en(wr_en), .addr(addr),
   .flush_bit(wdata[1]), .irq(irq), .fifo_en(fifo_en), .rx_cnt(rx_cnt),
   .div(div), .rx_valid(rx_valid), .rx_full(rx_full), .ovr_err(ovr_err));

// File: tb/sim_uart_chan.sv
module sim_uart_chan;
   localparam int CLK_P = 10;

   logic       clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, wr_en = 1'b0, rd_en = 1'b0;
   logic [2:0] addr = '0;
   logic [7:0] wdata = '0, rdata;
   logic       rxd = 1'b1, txd, irq;

   int checks = 0, errors = 0, D = 1;
   bit done = 0;
   logic [7:0] expq[$];

   always #(CLK_P/2) clk = ~clk;

   uart_chan u0 (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_en(wr_en), .rd_en(rd_en),
                 .addr(addr), .wdata(wdata), .rdata(rdata), .rxd(rxd), .txd(txd), .irq(irq));

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk); cs_n = 0; wr_en = 1; addr = a; wdata = d;
      @(negedge clk); cs_n = 1; wr_en = 0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk); cs_n = 0; rd_en = 1; addr = a;
      #1 d = rdata;
      @(negedge clk); cs_n = 1; rd_en = 0;
   endtask

   task automatic set_div(input int v);
      wr(3'd3, 8'(v)); wr(3'd4, 8'(v >> 8)); D = v;
   endtask

   // drive one frame on rxd; bad_stop holds the line low for 10*D clocks
   task automatic send(input logic [7:0] d, input bit pe, input bit odd,
                       input bit bad_par, input bit bad_stop);
      @(negedge clk); rxd = 0; repeat (16*D) @(negedge clk);
      for (int i = 0; i < 8; i++) begin rxd = d[i]; repeat (16*D) @(negedge clk); end
      if (pe) begin
         rxd = (^d) ^ odd ^ bad_par; repeat (16*D) @(negedge clk);
      end
      if (bad_stop) begin rxd = 0; repeat (10*D) @(negedge clk); end
      rxd = 1; repeat (16*D) @(negedge clk);
   endtask

   // sample txd at bit midpoints
   task automatic grab(input bit pe, output logic [7:0] d, output logic p, output logic s);
      while (txd !== 1'b0) @(negedge clk);
      repeat (8*D) @(negedge clk);
      for (int i = 0; i < 8; i++) begin repeat (16*D) @(negedge clk); d[i] = txd; end
      p = 1'b0;
      if (pe) begin repeat (16*D) @(negedge clk); p = txd; end
      repeat (16*D) @(negedge clk); s = txd;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0] v, d;
      logic p, s;
      int n;
      repeat (3) @(negedge clk); rst_n = 1;

      // R1 reset state
      rd(3'd5, v); chk("R1 status", v, 8'h60);
      rd(3'd2, v); chk("R1 qctl", v, 8'h00);
      chk("R1 irq", irq, 0); chk("R1 txd", txd, 1);

      // R10 unselected write is ignored
      @(negedge clk); cs_n = 1; wr_en = 1; addr = 3'd2; wdata = 8'hC1;
      @(negedge clk); wr_en = 0;
      rd(3'd2, v); chk("R10 qctl unchanged", v, 8'h00);

      set_div(2);

      // R3 frame layout, R13 idle bit
      wr(3'd0, 8'hA5);
      rd(3'd5, v); chk("R13 busy after write", v[6], 0);
      grab(0, d, p, s);
      chk("R3 tx data", d, 8'hA5); chk("R3 stop bit", s, 1);
      repeat (16*D) @(negedge clk);
      rd(3'd5, v); chk("R13 idle after frame", v[6], 1); chk("R9 tx empty", v[5], 1);

      // R11 bit duration
      set_div(3);
      wr(3'd0, 8'h01);
      while (txd !== 1'b0) @(negedge clk);
      n = 0;
      while (txd === 1'b0) begin n++; @(negedge clk); end
      chk("R11 start bit clocks", n, 48);
      repeat (16*D*10) @(negedge clk);
      set_div(2);

      // R4 parity polarity
      wr(3'd1, 8'h01); wr(3'd0, 8'h07); grab(1, d, p, s);
      chk("R4 even parity data", d, 8'h07); chk("R4 even parity bit", p, 1);
      wr(3'd1, 8'h03); wr(3'd0, 8'h07); grab(1, d, p, s);
      chk("R4 odd parity bit", p, 0); chk("R4 stop", s, 1);
      repeat (16*D) @(negedge clk);

      // R5 receive parity error (odd parity still set)
      send(8'h4E, 1, 1, 1, 0);
      rd(3'd5, v); chk("R5 parity err", v & 8'h0F, 8'h05);
      rd(3'd0, v); chk("R5 data", v, 8'h4E);
      rd(3'd5, v); chk("R9 cleared", v, 8'h60);
      wr(3'd1, 8'h00);

      // R2 single holding register and overrun
      send(8'h3C, 0, 0, 0, 0);
      chk("R8 irq holding mode", irq, 1);
      send(8'h5A, 0, 0, 0, 0);
      rd(3'd5, v); chk("R2 overrun+ready", v, 8'h63);
      rd(3'd0, v); chk("R2 first byte kept", v, 8'h3C);
      rd(3'd5, v); chk("R9 clear on read", v, 8'h60);

      // R6 framing error
      send(8'h81, 0, 0, 0, 1);
      repeat (32*D) @(negedge clk);
      rd(3'd5, v); chk("R6 framing err", v & 8'h0F, 8'h09);
      rd(3'd0, v); chk("R6 data", v, 8'h81);
      rd(3'd5, v); chk("R6 no spurious char", v, 8'h60);

      // R14 glitch rejected
      @(negedge clk); rxd = 0; repeat (4*D) @(negedge clk); rxd = 1;
      repeat (16*D*12) @(negedge clk);
      rd(3'd5, v); chk("R14 glitch ignored", v, 8'h60);

      // R8 level 01 -> 4 bytes
      wr(3'd2, 8'h41);
      for (int i = 0; i < 3; i++) begin send(8'(8'h10 + i), 0, 0, 0, 0); expq.push_back(8'(8'h10 + i)); end
      chk("R8 below level 4", irq, 0);
      send(8'h13, 0, 0, 0, 0); expq.push_back(8'h13);
      chk("R8 at level 4", irq, 1);
      while (expq.size() > 0) begin rd(3'd0, v); chk("R7 order", v, expq.pop_front()); end
      chk("R8 irq drops", irq, 0);

      // R7 depth with level 11 -> 14
      wr(3'd2, 8'hC1);
      for (int i = 0; i < 13; i++) begin send(8'(8'h20 + i), 0, 0, 0, 0); expq.push_back(8'(8'h20 + i)); end
      chk("R8 below level 14", irq, 0);
      for (int i = 13; i < 17; i++) begin
         send(8'(8'h20 + i), 0, 0, 0, 0);
         if (i < 16) expq.push_back(8'(8'h20 + i));
      end
      chk("R8 at level 14", irq, 1);
      rd(3'd5, v); chk("R7 overrun on 17th", v[1], 1);
      while (expq.size() > 0) begin rd(3'd0, v); chk("R7 16-deep order", v, expq.pop_front()); end
      rd(3'd5, v); chk("R7 drained", v, 8'h60);

      // R12 receive flush
      send(8'h66, 0, 0, 0, 0); send(8'h77, 0, 0, 0, 0);
      rd(3'd5, v); chk("R12 ready before flush", v[0], 1);
      wr(3'd2, 8'hC3);
      rd(3'd5, v); chk("R12 flushed", v[0], 0);
      chk("R12 irq low", irq, 0);

      // R7 transmit queue ordering
      wr(3'd0, 8'hC3); wr(3'd0, 8'h3C); wr(3'd0, 8'h99);
      grab(0, d, p, s); chk("R7 tx 1", d, 8'hC3);
      grab(0, d, p, s); chk("R7 tx 2", d, 8'h3C);
      grab(0, d, p, s); chk("R7 tx 3", d, 8'h99);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule